// File: doc/BRIEF.md
# Block Floating-Point Resource Block Compressor

This block compresses radio IQ data one resource block at a time. A resource block is twelve complex samples. The block gathers all twelve I/Q pairs into a local buffer and tracks the largest magnitude seen across the 24 real and imaginary parts. From that peak it derives a single left shift for the whole group. It then replays the buffer, scales each part, and keeps only the upper bits as a mantissa of the configured compressed width.

Each compressed group leaves as 25 beats on a valid/ready stream. The first beat is a parameter byte that carries the shared exponent. The 24 mantissas follow, in the order I0, Q0, I1, Q1 and so on up to Q11. Two configuration inputs give the input sample width and the compressed width. Both are held steady while a group is in flight.

Top module: `bfp_rb_compressor`

## Requirements
- R1: After synchronous reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Every 12 accepted samples produce exactly 25 output beats. Beat 0 has `out_kind`=0 (parameter). Beats 1..24 have `out_kind`=1 (mantissa), in the order I0,Q0,I1,Q1,...,I11,Q11. `out_last` is 1 only on beat 24.
- R3: Let peak be the largest absolute value over all 12 I and 12 Q parts, and let W be the input width. If peak < 2^(W-1), the shift is W-1-ceil(log2(peak)). Otherwise the shift is 0.
- R4: The parameter beat carries max(0, W-C-shift) in `out_data[3:0]`, where C is the compressed width. `out_data[15:4]` is 0 on that beat.
- R5: Each mantissa equals floor(x * 2^(shift+C-W)), sign-extended to 16 bits on `out_data`.
- R6: A scaled value above 2^(C-1)-1 gives 2^(C-1)-1. A scaled value below -2^(C-1) gives -2^(C-1).
- R7: A block of all zeros gives shift W-1, all mantissas 0, and an exponent of 0 for any legal C.
- R8: A part equal to -2^(W-1) counts as magnitude 2^(W-1), so the shift becomes 0.
- R9: `in_ready` is 0 from the cycle after the 12th sample is accepted until the final beat is taken. While `out_valid` is 1 and `out_ready` is 0, the output beat holds unchanged. No sample or beat is lost under any stall pattern.
- R10: A sample accepted with `in_first`=1 becomes element 0 of a new group. Any partially gathered samples are dropped.
- R11: W and C each work anywhere from 8 to 16, including C greater than W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_in_width | input | 5 | Input sample width W (8..16) |
| cfg_comp_width | input | 5 | Compressed mantissa width C (8..16) |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_first | input | 1 | Sample starts a new resource block |
| in_i | input | 16 | In-phase part, signed, sign-extended from W |
| in_q | input | 16 | Quadrature part, signed, sign-extended from W |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | 16 | Exponent byte or sign-extended mantissa |
| out_kind | output | 1 | 0 = parameter beat, 1 = mantissa beat |
| out_last | output | 1 | Final beat of the block |

## Verification
A corrupted peak register leads to a wrong exponent on the very first output beat of the affected group. It also scales every mantissa after it by the wrong amount, so a single bad bit shows up 25 times. A slip in the fill counter or the restart handling shifts the group boundary: mantissas come out pairing the wrong samples, or `in_ready` falls too early or too late, and this is visible within one group. A fault in the drain index or the stall handling reorders or repeats mantissas, or changes a held beat, and this shows on the next stalled or next transferred beat.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
    localparam int IQ_W     = 16;
    localparam int RE_N     = 12;
    localparam int CFG_BITS = 5;

    typedef enum logic {
        PH_FILL  = 1'b0,
        PH_DRAIN = 1'b1
    } phase_e;

    typedef struct packed {
        logic signed [IQ_W-1:0] re;
        logic signed [IQ_W-1:0] im;
    } iq_pair_t;
endpackage

// File: rtl/bfp_peak_tracker.sv
module bfp_peak_tracker #(
    parameter int W = 16,
    localparam int PW = W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                upd,
    input  logic                restart,
    input  logic signed [W-1:0] re,
    input  logic signed [W-1:0] im,
    output logic [PW-1:0]       peak
);
    logic [PW-1:0] mag_re, mag_im, pair_max, run_max;

    always_comb begin
        mag_re   = re[W-1] ? PW'(-{re[W-1], re}) : PW'({1'b0, re});
        mag_im   = im[W-1] ? PW'(-{im[W-1], im}) : PW'({1'b0, im});
        pair_max = (mag_re > mag_im) ? mag_re : mag_im;
        run_max  = (pair_max > peak) ? pair_max : peak;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            peak <= '0;
        end else if (upd) begin
            peak <= restart ? pair_max : run_max;
        end
    end
endmodule

// File: rtl/bfp_exp_unit.sv
module bfp_exp_unit #(
    parameter int W = 16,
    localparam int PW = W + 1
) (
    input  logic [PW-1:0]                  peak,
    input  logic [bfp_pkg::CFG_BITS-1:0]   cfg_w,
    input  logic [bfp_pkg::CFG_BITS-1:0]   cfg_c,
    output logic [4:0]                     shift,
    output logic [3:0]                     expo
);
    logic [PW-1:0] peak_m1, thr;
    int            clog;
    int            sh;
    int            d;

    always_comb begin
        peak_m1 = peak - PW'(1);
        thr     = PW'(1) << (cfg_w - 5'd1);
        clog    = 0;
        if (peak > PW'(1)) begin
            for (int k = 0; k < PW; k++) begin
                if (peak_m1[k]) clog = k + 1;
            end
        end
        if (peak >= thr) sh = 0;
        else             sh = int'(cfg_w) - 1 - clog;
        d     = int'(cfg_w) - int'(cfg_c) - sh;
        shift = 5'(sh);
        expo  = (d < 0) ? 4'd0 : 4'(d);
    end
endmodule

// File: rtl/bfp_mant_unit.sv
module bfp_mant_unit #(
    parameter int W = 16,
    localparam int XW = 3 * W
) (
    input  logic signed [W-1:0]            x,
    input  logic [4:0]                     shift,
    input  logic [bfp_pkg::CFG_BITS-1:0]   cfg_w,
    input  logic [bfp_pkg::CFG_BITS-1:0]   cfg_c,
    output logic [W-1:0]                   mant
);
    logic signed [XW-1:0] ext, v, hi, lo;

    always_comb begin
        ext = {{(XW-W){x[W-1]}}, x};
        v   = (ext <<< (int'(shift) + int'(cfg_c))) >>> cfg_w;
        hi  = $signed(XW'(1) << (cfg_c - 5'd1)) - XW'(1);
        lo  = -hi - XW'(1);
        if (v > hi)      mant = hi[W-1:0];
        else if (v < lo) mant = lo[W-1:0];
        else             mant = v[W-1:0];
    end
endmodule

// File: rtl/bfp_rb_compressor.sv
module bfp_rb_compressor
    import bfp_pkg::*;
#(
    parameter int RE_PER_BLK = RE_N,
    localparam int NBEAT = 2 * RE_PER_BLK + 1,
    localparam int BW    = $clog2(NBEAT),
    localparam int IW    = $clog2(RE_PER_BLK)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CFG_BITS-1:0]   cfg_in_width,
    input  logic [CFG_BITS-1:0]   cfg_comp_width,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic                  in_first,
    input  logic [IQ_W-1:0]       in_i,
    input  logic [IQ_W-1:0]       in_q,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [IQ_W-1:0]       out_data,
    output logic                  out_kind,
    output logic                  out_last
);
    phase_e          phase;
    logic [IW-1:0]   fill_cnt, wr_idx, rd_idx;
    logic [BW-1:0]   beat;
    iq_pair_t        store [RE_PER_BLK];
    logic            acc, take, drain_done;
    logic [IQ_W:0]   peak;
    logic [4:0]      shift;
    logic [3:0]      expo;
    logic [IQ_W-1:0] mant;
    logic [IQ_W-1:0] pick;

    assign in_ready   = (phase == PH_FILL);
    assign out_valid  = (phase == PH_DRAIN);
    assign acc        = in_valid && in_ready;
    assign take       = out_valid && out_ready;
    assign drain_done = take && (beat == BW'(NBEAT - 1));
    assign wr_idx     = in_first ? '0 : fill_cnt;

    // Sample buffer between the peak pass and the scaling pass
    for (genvar g = 0; g < RE_PER_BLK; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (acc && wr_idx == IW'(g)) begin
                store[g] <= '{re: in_i, im: in_q};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_FILL;
            fill_cnt <= '0;
            beat     <= '0;
        end else if (phase == PH_FILL) begin
            if (acc) begin
                if (wr_idx == IW'(RE_PER_BLK - 1)) begin
                    phase    <= PH_DRAIN;
                    fill_cnt <= '0;
                end else begin
                    fill_cnt <= wr_idx + IW'(1);
                end
            end
        end else if (take) begin
            if (drain_done) begin
                phase <= PH_FILL;
                beat  <= '0;
            end else begin
                beat <= beat + BW'(1);
            end
        end
    end

    bfp_peak_tracker #(.W(IQ_W)) u_peak (
        .clk     (clk),
        .rst     (rst),
        .clr     (drain_done),
        .upd     (acc),
        .restart (acc && in_first),
        .re      (in_i),
        .im      (in_q),
        .peak    (peak)
    );

    bfp_exp_unit #(.W(IQ_W)) u_exp (
        .peak  (peak),
        .cfg_w (cfg_in_width),
        .cfg_c (cfg_comp_width),
        .shift (shift),
        .expo  (expo)
    );

    // Beat 1 is I0, beat 2 is Q0, and so on
    always_comb begin
        rd_idx = (beat == '0) ? '0 : IW'((beat - BW'(1)) >> 1);
        pick   = beat[0] ? store[rd_idx].re : store[rd_idx].im;
    end

    bfp_mant_unit #(.W(IQ_W)) u_mant (
        .x     (pick),
        .shift (shift),
        .cfg_w (cfg_in_width),
        .cfg_c (cfg_comp_width),
        .mant  (mant)
    );

    assign out_kind = (beat != '0);
    assign out_last = (beat == BW'(NBEAT - 1));
    assign out_data = out_kind ? mant : {{(IQ_W-4){1'b0}}, expo};
endmodule

// File: rtl/bfp_rb_compressor_chk.sv
module bfp_rb_compressor_chk #(
    parameter int RE_PER_BLK = 12,
    parameter int DW = 16,
    localparam int NBEAT = 2 * RE_PER_BLK + 1
) (
    input logic          clk,
    input logic          rst,
    input logic [4:0]    cfg_comp_width,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_data,
    input logic          out_kind,
    input logic          out_last
);
    logic [5:0]         nacc;
    logic signed [DW:0] mval, mhi, mlo;

    always_ff @(posedge clk) begin
        if (rst) nacc <= '0;
        else if (out_valid && out_ready) nacc <= out_last ? 6'd0 : nacc + 6'd1;
    end

    always_comb begin
        mval = $signed({out_data[DW-1], out_data});
        mhi  = $signed((DW+1)'(1) << (cfg_comp_width - 5'd1)) - (DW+1)'(1);
        mlo  = -mhi - (DW+1)'(1);
    end

    a_r9_no_intake_while_draining: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_kind) && $stable(out_last));

    a_r4_param_upper_zero: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_kind |-> out_data[DW-1:4] == '0);

    a_r2_param_leads: assert property (@(posedge clk) disable iff (rst)
        out_valid && nacc == 6'd0 |-> !out_kind);

    a_r2_last_position: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_last |-> nacc == 6'(NBEAT - 1));

    a_r6_mant_in_range: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_kind |-> (mval <= mhi) && (mval >= mlo));
endmodule

bind bfp_rb_compressor bfp_rb_compressor_chk #(.RE_PER_BLK(RE_PER_BLK), .DW(16)) u_chk (.*);

// File: tb/sim_bfp_rb_compressor.sv
`timescale 1ns/1ps
module sim_bfp_rb_compressor;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  cfg_in_width, cfg_comp_width;
    logic        in_valid, in_first, out_ready;
    logic [15:0] in_i, in_q;
    logic        in_ready, out_valid, out_kind, out_last;
    logic [15:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    int vi [12];
    int vq [12];

    always #4 clk = ~clk;

    bfp_rb_compressor u0 (
        .clk(clk), .rst(rst), .cfg_in_width(cfg_in_width), .cfg_comp_width(cfg_comp_width),
        .in_valid(in_valid), .in_ready(in_ready), .in_first(in_first), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_kind(out_kind), .out_last(out_last)
    );

    task automatic check(input bit ok, input string req, input longint got, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, expv);
        end
    endtask

    function automatic int ref_shift(input int w);
        int pk = 0;
        int c = 0;
        for (int k = 0; k < 12; k++) begin
            int a = (vi[k] < 0) ? -vi[k] : vi[k];
            int b = (vq[k] < 0) ? -vq[k] : vq[k];
            if (a > pk) pk = a;
            if (b > pk) pk = b;
        end
        if (pk >= (1 << (w - 1))) return 0;
        while ((1 << c) < pk) c++;
        return w - 1 - c;
    endfunction

    function automatic int ref_mant(input int x, input int w, input int c, input int sh);
        longint v = (longint'(x) <<< (sh + c)) >>> w;
        longint hi = (longint'(1) << (c - 1)) - 1;
        if (v > hi) v = hi;
        if (v < -hi - 1) v = -hi - 1;
        return int'(v);
    endfunction

    function automatic int rnd(input int w, input int amp);
        return int'($urandom_range(0, 2 * amp)) - amp - ((amp == (1 << (w - 1)) - 1) ? int'($urandom_range(0, 1)) : 0);
    endfunction

    // Drives one group, drains it with a stall ratio, and checks every beat
    task automatic run_block(input int w, input int c, input int stall, input string req);
        int sh = ref_shift(w);
        int ex = (w - c - sh < 0) ? 0 : w - c - sh;
        int b = 0;
        int guard = 0;
        bit held = 0;
        logic [15:0] hd;
        cfg_in_width = 5'(w);
        cfg_comp_width = 5'(c);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_first = (k == 0);
            in_i = 16'(vi[k]); in_q = 16'(vq[k]);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_first = 1'b0;
        check(out_valid && !in_ready, {req, " R9 intake closed"}, {in_ready, out_valid}, 1);
        while (b < 25 && guard < 2000) begin
            guard++;
            if (held) check(out_data == hd, {req, " R9 held beat"}, out_data, hd);
            out_ready = ($urandom_range(0, 99) >= stall);
            if (out_valid && out_ready) begin
                int expv;
                if (b == 0) expv = ex;
                else expv = ref_mant((b % 2) ? vi[(b-1)/2] : vq[(b-1)/2], w, c, sh) & 16'hFFFF;
                check(out_data == 16'(expv), {req, (b == 0) ? " R4 exponent" : " R5 mantissa"}, out_data, expv);
                check(out_kind == (b != 0), {req, " R2 kind"}, out_kind, b != 0);
                check(out_last == (b == 24), {req, " R2 last"}, out_last, b == 24);
                b++;
                held = 0;
            end else begin
                held = out_valid;
                hd = out_data;
            end
            @(negedge clk);
        end
        out_ready = 1'b1;
        check(b == 25, {req, " R2 beat count"}, b, 25);
        check(in_ready && !out_valid, {req, " R9 intake reopens"}, {in_ready, out_valid}, 2);
    endtask

    task automatic t_reset;
        rst = 1'b1; in_valid = 0; in_first = 0; out_ready = 1; in_i = 0; in_q = 0;
        cfg_in_width = 16; cfg_comp_width = 9;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(!out_valid, "R1 out_valid after reset", out_valid, 0);
        check(in_ready, "R1 in_ready after reset", in_ready, 1);
    endtask

    task automatic t_random;
        for (int n = 0; n < 4; n++) begin
            for (int k = 0; k < 12; k++) begin vi[k] = rnd(16, 32767); vq[k] = rnd(16, 32767); end
            run_block(16, 9, 0, "R3 random");
        end
    endtask

    task automatic t_small;
        for (int k = 0; k < 12; k++) begin vi[k] = rnd(16, 5); vq[k] = rnd(16, 5); end
        run_block(16, 8, 0, "R3 small amplitude");
        for (int k = 0; k < 12; k++) begin vi[k] = 0; vq[k] = 0; end
        vq[7] = -1;
        run_block(16, 12, 0, "R3 unit peak");
    endtask

    task automatic t_full_scale;
        for (int k = 0; k < 12; k++) begin vi[k] = rnd(16, 300); vq[k] = rnd(16, 300); end
        vq[5] = -32768;
        run_block(16, 9, 0, "R8 negative full scale");
        for (int k = 0; k < 12; k++) begin vi[k] = rnd(12, 200); vq[k] = rnd(12, 200); end
        vi[3] = 1024; vq[9] = -1024;
        run_block(12, 10, 0, "R6 saturation");
    endtask

    task automatic t_zero;
        for (int k = 0; k < 12; k++) begin vi[k] = 0; vq[k] = 0; end
        run_block(16, 9, 0, "R7 zero block");
    endtask

    task automatic t_widths;
        for (int k = 0; k < 12; k++) begin vi[k] = rnd(8, 127); vq[k] = rnd(8, 127); end
        run_block(8, 16, 0, "R11 W8 C16");
        for (int k = 0; k < 12; k++) begin vi[k] = rnd(9, 40); vq[k] = rnd(9, 40); end
        run_block(9, 8, 0, "R11 W9 C8");
        for (int k = 0; k < 12; k++) begin vi[k] = rnd(14, 8191); vq[k] = rnd(14, 8191); end
        run_block(14, 12, 0, "R11 W14 C12");
    endtask

    task automatic t_backpressure;
        for (int n = 0; n < 3; n++) begin
            for (int k = 0; k < 12; k++) begin vi[k] = rnd(16, 9000); vq[k] = rnd(16, 9000); end
            run_block(16, 10, 60, "R9 backpressure");
        end
    endtask

    task automatic t_restart;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            in_valid = 1; in_first = (k == 0); in_i = 16'(32767); in_q = 16'(-32767);
            @(posedge clk);
        end
        for (int k = 0; k < 12; k++) begin vi[k] = rnd(16, 60); vq[k] = rnd(16, 60); end
        run_block(16, 9, 0, "R10 restart");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R2 watchdog: got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_random();
        t_small();
        t_full_scale();
        t_zero();
        t_widths();
        t_backpressure();
        t_restart();
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule